// File: doc/BRIEF.md
# Prioritized Interrupt Request Core

This block merges eight interrupt request lines into a single interrupt output toward a processor. It keeps three 8-bit registers: a request register with the pending lines, a mask register that silences chosen lines, and an in-service register with the levels the processor is currently handling. Priority is fixed. Line 0 ranks highest and line 7 lowest. A set in-service bit holds back every request of the same or lower rank until an end-of-interrupt clears it.

A separate command decoder supplies the configuration: the trigger mode, a 5-bit vector base and an automatic end-of-interrupt flag. It also drives the mask write port and the end-of-interrupt strobe, and it reads all three registers back. The processor answers the interrupt output with a one-cycle acknowledge pulse. In that same cycle it takes an 8-bit vector made of the base and the 3-bit level of the winning request.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the request, mask and in-service registers read 0, and the interrupt output is low.
- R2: A write through the mask port takes effect at the next clock edge at any time, and the mask register reads back the written value. A masked line still shows in the request register, but it never raises the interrupt output and is never selected.
- R3: Among the pending, unmasked and unblocked lines, the one with the lowest index wins. The vector output is {base[4:0], level[2:0]} of that line.
- R4: An acknowledge while the interrupt output is high clears the winner's request bit at the next edge. When automatic end-of-interrupt is off, the same edge sets that line's in-service bit.
- R5: While in-service bit k is set, requests on lines k through 7 do not raise the interrupt output. Requests on lines below k still raise it.
- R6: A non-specific end-of-interrupt (eoi_specific = 0) clears only the lowest-index set bit of the in-service register.
- R7: A specific end-of-interrupt (eoi_specific = 1) clears exactly the in-service bit named by eoi_level, even when that bit is not the highest-priority one, and leaves the other bits alone.
- R8: With automatic end-of-interrupt on, an acknowledge leaves the in-service register unchanged.
- R9: In edge mode (cfg_level_mode = 0), a rising input sets the request bit. The bit stays set after the input falls and is cleared only by acknowledge. An input that stays high does not request again after it is acknowledged.
- R10: In level mode (cfg_level_mode = 1), the request register copies the input lines on every edge, except that the bit acknowledged in that cycle is cleared.
- R11: An acknowledge while the interrupt output is low changes no register. During that cycle the vector output reads {base, 3'b111}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, line 0 highest priority |
| cfg_level_mode | input | 1 | 1 = level trigger, 0 = rising-edge trigger |
| cfg_vec_base | input | 5 | Upper five bits of the returned vector |
| cfg_auto_eoi | input | 1 | 1 = no in-service bit is kept on acknowledge |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | Mask value, 1 = line masked |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_specific | input | 1 | 1 = clear the named level, 0 = clear the highest set level |
| eoi_level | input | 3 | Level for a specific end-of-interrupt |
| ack | input | 1 | One-cycle acknowledge from the processor |
| intr_out | output | 1 | Interrupt output to the processor |
| ack_vector | output | 8 | Vector of the current winner, valid in the acknowledge cycle |
| rd_request | output | 8 | Request register readback |
| rd_mask | output | 8 | Mask register readback |
| rd_inservice | output | 8 | In-service register readback |

## Verification
The priority selector is swept over all 256 request patterns under four mask patterns: none, all, and two interleaved. These sweeps separate the lowest-index selection from the masking, and show that masked lines are still recorded. Directed sequences then stack in-service levels so that blocking of equal, lower and higher lines can be told apart. A specific end-of-interrupt on a bit that is not the highest tells it apart from a non-specific one. Edge and level capture are compared on inputs that pulse, stay high and drop before acknowledge, and a no-winner acknowledge shows that the default vector changes no register.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_mode_e;

   typedef enum logic {
      EOI_TOP   = 1'b0,
      EOI_NAMED = 1'b1
   } eoi_kind_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: the lowest set index wins; the default index is the last one.
module irq_prio_pick #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [LW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = LW'(N - 1);
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = LW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture
   import irq_prio_pkg::*;
#(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  trig_mode_e   mode,
   input  logic [N-1:0] clr,
   output logic [N-1:0] req
);
   logic [N-1:0] irq_q;

   for (genvar g = 0; g < N; g++) begin : g_line
      logic rise;
      assign rise = irq_in[g] & ~irq_q[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_q[g] <= 1'b0;
            req[g]   <= 1'b0;
         end else begin
            irq_q[g] <= irq_in[g];
            if (mode == TRIG_LEVEL)
               req[g] <= irq_in[g] & ~clr[g];
            else
               req[g] <= (req[g] & ~clr[g]) | rise;
         end
      end

      // R9: a pending edge request survives until acknowledged
      a_r9_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == TRIG_EDGE && req[g] && !clr[g]) |=> (mode == TRIG_LEVEL || req[g]));
      // R10: level mode copies the line unless it is being acknowledged
      a_r10_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
         (mode == TRIG_LEVEL && !clr[g]) |=> (req[g] == $past(irq_in[g])));
   end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
   import irq_prio_pkg::*;
#(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_mask,
   input  logic          eoi_valid,
   input  eoi_kind_e     eoi_kind,
   input  logic [LW-1:0] eoi_level,
   output logic [N-1:0]  isr,
   output logic          top_found,
   output logic [LW-1:0] top_idx
);
   logic [N-1:0] eoi_clr;

   irq_prio_pick #(.N(N), .LW(LW)) u_top (
      .vec   (isr),
      .found (top_found),
      .idx   (top_idx)
   );

   always_comb begin
      eoi_clr = '0;
      if (eoi_valid) begin
         if (eoi_kind == EOI_NAMED)
            eoi_clr = N'(1) << eoi_level;
         else if (top_found)
            eoi_clr = N'(1) << top_idx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~eoi_clr) | set_mask;
   end

   // R6: a non-specific end-of-interrupt removes exactly one bit
   a_r6_one_bit_gone: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && eoi_kind == EOI_TOP && set_mask == '0 && isr != '0)
      |=> ($countones(isr) + 1 == $countones($past(isr))));
   // R7: a specific end-of-interrupt removes the named bit and keeps the rest
   a_r7_named_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && eoi_kind == EOI_NAMED && set_mask == '0)
      |=> (isr == ($past(isr) & ~(N'(1) << $past(eoi_level)))));
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
   import irq_prio_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8,
   parameter int LVL_W     = $clog2(NUM_LINES),
   parameter int BASE_W    = VEC_W - LVL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 cfg_level_mode,
   input  logic [BASE_W-1:0]    cfg_vec_base,
   input  logic                 cfg_auto_eoi,
   input  logic                 mask_we,
   input  logic [NUM_LINES-1:0] mask_wdata,
   input  logic                 eoi_valid,
   input  logic                 eoi_specific,
   input  logic [LVL_W-1:0]     eoi_level,
   input  logic                 ack,
   output logic                 intr_out,
   output logic [VEC_W-1:0]     ack_vector,
   output logic [NUM_LINES-1:0] rd_request,
   output logic [NUM_LINES-1:0] rd_mask,
   output logic [NUM_LINES-1:0] rd_inservice
);
   localparam int N = NUM_LINES;

   if (N != (1 << LVL_W)) begin : g_chk_pow2
      $error("NUM_LINES must be a power of two");
   end
   if (VEC_W <= LVL_W) begin : g_chk_vec
      $error("VEC_W must exceed the level width");
   end

   logic [N-1:0]     req, mask_q, isr, allow, cand, take_clr, isr_set;
   logic             cand_found, isr_found, take;
   logic [LVL_W-1:0] cand_idx, isr_top;

   irq_req_capture #(.N(N)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_in),
      .mode   (trig_mode_e'(cfg_level_mode)),
      .clr    (take_clr),
      .req    (req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wdata;
   end

   // Only levels ranked strictly above the highest in-service level may pass
   for (genvar g = 0; g < N; g++) begin : g_allow
      localparam logic [LVL_W-1:0] LV = LVL_W'(g);
      assign allow[g] = !isr_found || (LV < isr_top);
   end

   assign cand = req & ~mask_q & allow;

   irq_prio_pick #(.N(N), .LW(LVL_W)) u_pick (
      .vec   (cand),
      .found (cand_found),
      .idx   (cand_idx)
   );

   assign take     = ack & cand_found;
   assign take_clr = take ? (N'(1) << cand_idx) : '0;
   assign isr_set  = cfg_auto_eoi ? '0 : take_clr;

   irq_inservice #(.N(N), .LW(LVL_W)) u_isr (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_mask  (isr_set),
      .eoi_valid (eoi_valid),
      .eoi_kind  (eoi_kind_e'(eoi_specific)),
      .eoi_level (eoi_level),
      .isr       (isr),
      .top_found (isr_found),
      .top_idx   (isr_top)
   );

   assign intr_out     = cand_found;
   assign ack_vector   = {cfg_vec_base, cand_idx};
   assign rd_request   = req;
   assign rd_mask      = mask_q;
   assign rd_inservice = isr;

   // R2: the output is raised only by a pending line that is not masked
   a_r2_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      intr_out |-> ((rd_request & ~rd_mask) != '0));
   // R4: an acknowledged winner is in service at the next edge
   a_r4_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && intr_out && !cfg_auto_eoi && !eoi_valid)
      |=> rd_inservice[$past(ack_vector[LVL_W-1:0])]);
   // R8: with automatic end-of-interrupt the in-service register is untouched
   a_r8_auto_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && cfg_auto_eoi && !eoi_valid) |=> $stable(rd_inservice));
   // R11: an acknowledge with no winner changes no in-service state
   a_r11_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !intr_out && !eoi_valid) |=> $stable(rd_inservice));
   // R5: the output is never raised for a line ranked at or below the highest in-service level
   a_r5_blocking: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_out && rd_inservice != '0)
      |-> ((N'(1) << ack_vector[LVL_W-1:0]) < (rd_inservice & -rd_inservice)));
endmodule

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq_in;
   logic       cfg_level_mode, cfg_auto_eoi, mask_we, eoi_valid, eoi_specific, ack;
   logic [4:0] cfg_vec_base;
   logic [7:0] mask_wdata;
   logic [2:0] eoi_level;
   logic       intr_out;
   logic [7:0] ack_vector, rd_request, rd_mask, rd_inservice;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   irq_prio_core dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_level_mode(cfg_level_mode),
      .cfg_vec_base(cfg_vec_base), .cfg_auto_eoi(cfg_auto_eoi), .mask_we(mask_we),
      .mask_wdata(mask_wdata), .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
      .eoi_level(eoi_level), .ack(ack), .intr_out(intr_out), .ack_vector(ack_vector),
      .rd_request(rd_request), .rd_mask(rd_mask), .rd_inservice(rd_inservice)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [2:0] lowest(input logic [7:0] v);
      logic [2:0] r = 3'd7;
      for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
      return r;
   endfunction

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic do_eoi(input logic spec, input logic [2:0] lvl);
      eoi_valid = 1'b1; eoi_specific = spec; eoi_level = lvl;
      tick();
      eoi_valid = 1'b0; eoi_specific = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] v);
      irq_in = v; tick(); irq_in = 8'h00; tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] masks [4] = '{8'h00, 8'hA5, 8'h3C, 8'hFF};
      rst_n = 1'b0; irq_in = '0; cfg_level_mode = 1'b1; cfg_auto_eoi = 1'b1;
      cfg_vec_base = 5'h13; mask_we = 1'b0; mask_wdata = '0;
      eoi_valid = 1'b0; eoi_specific = 1'b0; eoi_level = '0; ack = 1'b0;
      @(negedge clk); tick(); tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 request", rd_request, 8'h00);
      chk("R1 mask", rd_mask, 8'h00);
      chk("R1 inservice", rd_inservice, 8'h00);
      chk("R1 intr", {7'd0, intr_out}, 8'h00);

      // R2/R3 sweep in level mode: every request pattern under four masks
      foreach (masks[k]) begin
         for (int p = 0; p < 256; p++) begin
            logic [7:0] pv = 8'(p);
            logic [7:0] live = pv & ~masks[k];
            irq_in = pv; mask_we = 1'b1; mask_wdata = masks[k];
            tick();
            mask_we = 1'b0;
            chk("R2 mask readback", rd_mask, masks[k]);
            chk("R10 request copies input", rd_request, pv);
            chk("R2 masked lines silent", {7'd0, intr_out}, {7'd0, |live});
            if (live != 0) chk("R3 vector", ack_vector, {5'h13, lowest(live)});
         end
      end
      irq_in = 8'h00; mask_we = 1'b1; mask_wdata = 8'h00; tick(); mask_we = 1'b0;

      // Edge mode with in-service bookkeeping
      cfg_level_mode = 1'b0; cfg_auto_eoi = 1'b0; cfg_vec_base = 5'h0B;
      tick();
      pulse(8'h24);
      chk("R9 edge held after fall", rd_request, 8'h24);
      chk("R3 vector line 2", ack_vector, {5'h0B, 3'd2});
      do_ack();
      chk("R4 request cleared", rd_request, 8'h20);
      chk("R4 inservice set", rd_inservice, 8'h04);
      chk("R5 lower line blocked", {7'd0, intr_out}, 8'h00);
      pulse(8'h02);
      chk("R5 higher line passes", {7'd0, intr_out}, 8'h01);
      chk("R5 higher vector", ack_vector, {5'h0B, 3'd1});
      do_ack();
      chk("R4 stacked inservice", rd_inservice, 8'h06);
      do_eoi(1'b0, 3'd6);
      chk("R6 top bit only", rd_inservice, 8'h04);
      chk("R5 still blocked", {7'd0, intr_out}, 8'h00);
      do_eoi(1'b1, 3'd2);
      chk("R7 named clear", rd_inservice, 8'h00);
      chk("R5 released vector", ack_vector, {5'h0B, 3'd5});
      do_ack();
      pulse(8'h08);
      chk("R5 line 3 above line 5", {7'd0, intr_out}, 8'h01);
      do_ack();
      chk("R4 two in service", rd_inservice, 8'h28);
      do_eoi(1'b1, 3'd5);
      chk("R7 non-top named clear", rd_inservice, 8'h08);
      do_eoi(1'b0, 3'd0);
      chk("R6 last bit", rd_inservice, 8'h00);

      irq_in = 8'h80; tick();
      do_ack();
      tick(); tick();
      chk("R9 steady high no re-request", rd_request, 8'h00);
      chk("R9 line 7 in service", rd_inservice, 8'h80);
      do_eoi(1'b0, 3'd0);
      irq_in = 8'h00; tick();

      // R11 acknowledge with no winner
      ack = 1'b1;
      chk("R11 intr low", {7'd0, intr_out}, 8'h00);
      chk("R11 default vector", ack_vector, {5'h0B, 3'd7});
      tick(); ack = 1'b0;
      chk("R11 inservice unchanged", rd_inservice, 8'h00);
      chk("R11 request unchanged", rd_request, 8'h00);

      // R10 level mode follows input
      cfg_level_mode = 1'b1;
      irq_in = 8'h10; tick();
      chk("R10 level captured", rd_request, 8'h10);
      irq_in = 8'h00; tick();
      chk("R10 level dropped", rd_request, 8'h00);
      irq_in = 8'h10; tick();
      do_ack();
      chk("R10 acked bit cleared", rd_request, 8'h00);
      chk("R4 level inservice", rd_inservice, 8'h10);
      tick();
      chk("R10 reloads from input", rd_request, 8'h10);
      chk("R5 equal level blocked", {7'd0, intr_out}, 8'h00);
      do_eoi(1'b0, 3'd0);
      chk("R6 release equal", {7'd0, intr_out}, 8'h01);
      irq_in = 8'h00; tick();

      // R8 automatic end-of-interrupt
      cfg_auto_eoi = 1'b1;
      irq_in = 8'h01; tick();
      do_ack();
      chk("R8 no inservice kept", rd_inservice, 8'h00);
      tick();
      chk("R8 no blocking after ack", {7'd0, intr_out}, 8'h01);
      irq_in = 8'h00; tick();

      // R2 mask write while a request is pending
      irq_in = 8'h40; mask_we = 1'b1; mask_wdata = 8'h40; tick(); mask_we = 1'b0;
      chk("R2 masked pending recorded", rd_request, 8'h40);
      chk("R2 masked pending silent", {7'd0, intr_out}, 8'h00);
      mask_we = 1'b1; mask_wdata = 8'h00; tick(); mask_we = 1'b0;
      chk("R2 unmask raises", ack_vector, {5'h0B, 3'd6});

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule